// File: doc/BRIEF.md
# Interval and Capture Timer

A 16-bit timer with one 8-bit control register, a data register and a counter readback, all reached through a plain register bus. The bus has a write strobe, a 2-bit address, write data and read data. Reads are combinational from the addressed register. Writes take effect at the clock edge where the strobe is high. The block moves no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal.

The counter advances once per tick. A tick comes from a free-running 4-bit prescaler (divide by 4, 8 or 16) or from rising edges of an external toggle input. In interval mode the counter is compared with the data register. When they are equal the counter clears and a match event fires. In the three capture modes the counter runs freely. A selected edge on the capture input copies the counter into the data register.

Each interrupt output is its pending flag gated by its enable. The match/capture flag is cleared by software. The overflow flag is cleared by an acknowledge pulse.

Top module: `interval_capture_timer`

## Requirements
- R1: After reset every control field is 0, and the counter, data register, both pending flags and both interrupt outputs are 0.
- R2: Control bits [7:6] pick the tick source: 00 divides the clock by 4, 01 by 8 and 10 by 16, all taken from a free-running 4-bit prescaler. 11 gives one tick per rising edge of `tff_in` after a two-flop synchronizer. Each tick adds 1 to the counter, which reads at address 2.
- R3: Control bits [5:4] = 00 select interval mode. A tick while the counter equals the data register raises a match event, sets the match/capture pending flag and loads 0 into the counter.
- R4: A tick with the counter at all ones and no match wraps the counter to 0 and sets the overflow pending flag, in every mode.
- R5: Control bits [5:4] = 01, 10 and 11 capture on rising edges, falling edges and both edges of `cap_in`, seen through a two-flop synchronizer. A capture copies the counter into the data register and sets the match/capture pending flag. The counter keeps counting.
- R6: The control register is at address 0. Bit 3 written as 1 clears the counter, and bit 3 always reads 0. Bit 2 enables the overflow interrupt and bit 1 enables the match/capture interrupt. Bit 0 reads the match/capture pending flag.
- R7: A control write with bit 0 = 0 clears the match/capture pending flag. A write with bit 0 = 1 leaves it as it is. A match or capture in the same cycle as a clear leaves the flag set.
- R8: A high `ovf_ack` clears the overflow pending flag. An overflow in the same cycle as an acknowledge leaves the flag set.
- R9: `irq_ovf` equals the overflow pending flag ANDed with bit 2. `irq_mc` equals the match/capture pending flag ANDed with bit 1.
- R10: Address 1 reads the data register. A write there loads the compare value in interval mode and is ignored in the capture modes. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 counter |
| bus_wdata | input | CNT_W | Write data (control uses bits [7:0]) |
| bus_rdata | output | CNT_W | Read data of the addressed register |
| tff_in | input | 1 | External toggle source for tick select 11 |
| cap_in | input | 1 | Asynchronous capture input |
| ovf_ack | input | 1 | Overflow interrupt acknowledge pulse |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_mc | output | 1 | Match/capture interrupt request |

## Verification
The hardest case to reach from the ports is the counter wrap. It needs a full 2^CNT_W ticks, and each tick costs at least two clocks. The bench builds the block with an 8-bit counter and drives `tff_in` as a toggle on every clock. A wrap then comes every 512 cycles, while captures, acknowledges and pending-clear writes are scattered on other periods so that they sometimes land in the same cycle as an event. A behavioural model runs beside the block and checks both interrupts and the addressed read data on every clock, with the address rotating over all four registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {CK_DIV4 = 2'b00, CK_DIV8 = 2'b01, CK_DIV16 = 2'b10, CK_EXT = 2'b11} clk_sel_e;
  typedef enum logic [1:0] {MD_INTERVAL = 2'b00, MD_CAP_RISE = 2'b01, MD_CAP_FALL = 2'b10, MD_CAP_BOTH = 2'b11} mode_e;
  typedef enum logic [1:0] {RA_CTRL = 2'b00, RA_DATA = 2'b01, RA_COUNT = 2'b10, RA_NONE = 2'b11} reg_addr_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_q,
  output logic prev_q
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign sync_q = sh[STAGES-1];
  assign prev_q = sh[STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_in,
  output logic     tick
);
  localparam int PSC_W = 4;

  logic [PSC_W-1:0] psc;
  logic ext_sync, ext_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc <= '0;
    else        psc <= psc + PSC_W'(1);
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in), .sync_q(ext_sync), .prev_q(ext_prev)
  );

  always_comb begin
    case (sel)
      CK_DIV4:  tick = &psc[1:0];
      CK_DIV8:  tick = &psc[2:0];
      CK_DIV16: tick = &psc[3:0];
      default:  tick = ext_sync & ~ext_prev;
    endcase
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  mode_e            mode,
  input  logic             sw_clr,
  input  logic             cap_sync,
  input  logic             cap_prev,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] data,
  output logic             match_evt,
  output logic             ovf_evt,
  output logic             cap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cap_rise, cap_fall;

  assign cap_rise = cap_sync & ~cap_prev;
  assign cap_fall = ~cap_sync & cap_prev;

  always_comb begin
    case (mode)
      MD_CAP_RISE: cap_evt = cap_rise;
      MD_CAP_FALL: cap_evt = cap_fall;
      MD_CAP_BOTH: cap_evt = cap_rise | cap_fall;
      default:     cap_evt = 1'b0;
    endcase
  end

  assign match_evt = tick && (mode == MD_INTERVAL) && (cnt == data);
  assign ovf_evt   = tick && !match_evt && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (sw_clr || match_evt) cnt <= '0;
    else if (tick)                cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              data <= '0;
    else if (cap_evt)                        data <= cnt;
    else if (cmp_wr && mode == MD_INTERVAL)  data <= cmp_wdata;
  end

  // R3
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cnt == '0));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_clr && !match_evt && !ovf_evt) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R5
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (data == $past(cnt)));
  // R10
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_INTERVAL && !cap_evt) |=> $stable(data));
endmodule

// File: rtl/interval_capture_timer.sv
module interval_capture_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tff_in,
  input  logic             cap_in,
  input  logic             ovf_ack,
  output logic             irq_ovf,
  output logic             irq_mc
);
  clk_sel_e         clk_sel_q;
  mode_e            mode_q;
  logic             en_ovf_q, en_mc_q, mc_pend_q, ovf_pend_q;
  logic             tick, cap_sync, cap_prev;
  logic             match_evt, ovf_evt, cap_evt, mc_set;
  logic             ctrl_wr, sw_clr, cmp_wr;
  logic [CNT_W-1:0] cnt, data;
  reg_addr_e        addr;

  assign addr    = reg_addr_e'(bus_addr);
  assign ctrl_wr = bus_wr && addr == RA_CTRL;
  assign sw_clr  = ctrl_wr && bus_wdata[3];
  assign cmp_wr  = bus_wr && addr == RA_DATA;
  assign mc_set  = match_evt | cap_evt;

  tmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel_q), .ext_in(tff_in), .tick(tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .sync_q(cap_sync), .prev_q(cap_prev)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .sw_clr(sw_clr),
    .cap_sync(cap_sync), .cap_prev(cap_prev), .cmp_wr(cmp_wr), .cmp_wdata(bus_wdata),
    .cnt(cnt), .data(data), .match_evt(match_evt), .ovf_evt(ovf_evt), .cap_evt(cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q <= CK_DIV4;
      mode_q    <= MD_INTERVAL;
      en_ovf_q  <= 1'b0;
      en_mc_q   <= 1'b0;
    end else if (ctrl_wr) begin
      clk_sel_q <= clk_sel_e'(bus_wdata[7:6]);
      mode_q    <= mode_e'(bus_wdata[5:4]);
      en_ovf_q  <= bus_wdata[2];
      en_mc_q   <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         mc_pend_q <= 1'b0;
    else if (mc_set)                    mc_pend_q <= 1'b1;
    else if (ctrl_wr && !bus_wdata[0])  mc_pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_pend_q <= 1'b0;
    else if (ovf_evt) ovf_pend_q <= 1'b1;
    else if (ovf_ack) ovf_pend_q <= 1'b0;
  end

  assign irq_ovf = ovf_pend_q & en_ovf_q;
  assign irq_mc  = mc_pend_q & en_mc_q;

  always_comb begin
    case (addr)
      RA_CTRL:  bus_rdata = CNT_W'({clk_sel_q, mode_q, 1'b0, en_ovf_q, en_mc_q, mc_pend_q});
      RA_DATA:  bus_rdata = data;
      RA_COUNT: bus_rdata = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  // R7
  mc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_set |=> mc_pend_q);
  // R8
  ovf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack && !ovf_evt) |=> !ovf_pend_q);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_pend_q);
endmodule

// File: tb/test_interval_capture_timer.sv
module test_interval_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic tff_in = 1'b0, cap_in = 1'b0, ovf_ack = 1'b0;
  logic irq_ovf, irq_mc;

  int n_chk = 0, n_err = 0, cyc = 0;
  int cur_ctrl = 0;

  // reference state
  int m_psc, m_cnt, m_data, m_clk, m_mode;
  bit m_eo, m_em, m_mp, m_op;
  bit t1, t2, t3, c1, c2, c3;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_capture_timer #(.CNT_W(CW)) i_interval_capture_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tff_in(tff_in),
    .cap_in(cap_in), .ovf_ack(ovf_ack), .irq_ovf(irq_ovf), .irq_mc(irq_mc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit tk, mt, ov, cp, rs, fl, cw;
    if (!rst_n) begin
      m_psc = 0; m_cnt = 0; m_data = 0; m_clk = 0; m_mode = 0;
      m_eo = 0; m_em = 0; m_mp = 0; m_op = 0;
      t1 = 0; t2 = 0; t3 = 0; c1 = 0; c2 = 0; c3 = 0;
    end else begin
      case (m_clk)
        0: tk = (m_psc % 4) == 3;
        1: tk = (m_psc % 8) == 7;
        2: tk = m_psc == 15;
        default: tk = t2 && !t3;
      endcase
      rs = c2 && !c3;
      fl = !c2 && c3;
      mt = tk && m_mode == 0 && m_cnt == m_data;
      ov = tk && !mt && m_cnt == MAXV;
      cp = (m_mode == 1 && rs) || (m_mode == 2 && fl) || (m_mode == 3 && (rs || fl));
      cw = bus_wr && bus_addr == 2'd0;
      if (cp) m_data = m_cnt;
      else if (bus_wr && bus_addr == 2'd1 && m_mode == 0) m_data = int'(bus_wdata);
      if ((cw && bus_wdata[3]) || mt) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) & MAXV;
      if (mt || cp) m_mp = 1;
      else if (cw && !bus_wdata[0]) m_mp = 0;
      if (ov) m_op = 1;
      else if (ovf_ack) m_op = 0;
      if (cw) begin
        m_clk = int'(bus_wdata[7:6]); m_mode = int'(bus_wdata[5:4]);
        m_eo = bus_wdata[2]; m_em = bus_wdata[1];
      end
      m_psc = (m_psc + 1) % 16;
      t3 = t2; t2 = t1; t1 = tff_in;
      c3 = c2; c2 = c1; c1 = cap_in;
    end
  end

  always @(negedge clk) begin
    int exp_rd;
    if (rst_n) begin
      chk(irq_ovf === (m_op & m_eo), "R8 R9 irq_ovf", irq_ovf, m_op & m_eo);
      chk(irq_mc === (m_mp & m_em), "R7 R9 irq_mc", irq_mc, m_mp & m_em);
      case (bus_addr)
        2'd0: exp_rd = (m_clk << 6) | (m_mode << 4) | (m_eo << 2) | (m_em << 1) | m_mp;
        2'd1: exp_rd = m_data;
        2'd2: exp_rd = m_cnt;
        default: exp_rd = 0;
      endcase
      case (bus_addr)
        2'd0: chk(bus_rdata === CW'(exp_rd), "R6 R7 control readback", bus_rdata, exp_rd);
        2'd1: chk(bus_rdata === CW'(exp_rd), "R3 R5 R10 data readback", bus_rdata, exp_rd);
        2'd2: chk(bus_rdata === CW'(exp_rd), "R2 R3 R4 counter readback", bus_rdata, exp_rd);
        default: chk(bus_rdata === CW'(exp_rd), "R10 spare address", bus_rdata, exp_rd);
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected<=190000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = CW'(d); ovf_ack = 1'b0;
    if (a == 0) cur_ctrl = d & 8'hF7;
  endtask

  // n cycles; optional tff toggle, capture toggle, ack and pending-clear periods
  task automatic run(input int n, input bit tog, input int cap_per, input int ack_per, input int clr_per);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 2'(i % 4); ovf_ack = 1'b0;
      if (tog) tff_in = ~tff_in;
      if (cap_per > 0 && (i % cap_per) == cap_per - 1) cap_in = ~cap_in;
      if (ack_per > 0 && (i % ack_per) == ack_per - 1) ovf_ack = 1'b1;
      if (clr_per > 0 && (i % clr_per) == clr_per - 1) begin
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = CW'(cur_ctrl & 8'hFE);
      end
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state at the ports
    bus_addr = 2'd0; #1;
    chk(bus_rdata === '0, "R1 control after reset", bus_rdata, 0);
    bus_addr = 2'd1; #1;
    chk(bus_rdata === '0, "R1 data after reset", bus_rdata, 0);
    bus_addr = 2'd2; #1;
    chk(bus_rdata === '0, "R1 counter after reset", bus_rdata, 0);
    chk(irq_ovf === 1'b0 && irq_mc === 1'b0, "R1 irqs after reset", {irq_ovf, irq_mc}, 0);
    rst_n = 1'b1;
    run(10, 0, 0, 0, 0);
    // R3 interval /4 compare 5, match irq enabled
    wr(1, 5); wr(0, 8'h02); run(80, 0, 0, 0, 0);
    // R7 writing bit0=1 keeps pending, bit0=0 clears
    wr(0, 8'h03); run(3, 0, 0, 0, 0);
    wr(0, 8'h02); run(20, 0, 0, 0, 0);
    // R2 divide by 8 and 16
    wr(1, 3); wr(0, 8'h42); run(100, 0, 0, 0, 0);
    wr(0, 8'h82); run(150, 0, 0, 0, 0);
    // R2 external toggle source
    wr(0, 8'hC2); run(60, 1, 0, 0, 0);
    // R6 software counter clear
    wr(0, 8'hCA); run(6, 1, 0, 0, 0);
    // R4 wrap in interval mode after compare falls below the counter
    wr(1, 200); wr(0, 8'hC6); run(400, 1, 0, 0, 0);
    wr(1, 2); run(700, 1, 0, 97, 0);
    // R5 capture rising with wrap, acks, clears, ignored data write (R10)
    wr(0, 8'hD6); run(1200, 1, 37, 131, 23);
    wr(1, 8'hAA); run(300, 1, 13, 0, 0);
    // R5 falling and both edges, clears colliding with captures (R7)
    wr(0, 8'hE6); run(1200, 1, 11, 61, 7);
    wr(0, 8'hF6); run(1200, 0, 5, 0, 3);
    wr(1, 8'h55); run(50, 0, 9, 0, 0);
    // R9 enables off while pending
    wr(0, 8'hF0); run(100, 1, 17, 0, 0);
    // back to interval, spare address
    wr(0, 8'h06); wr(3, 8'hFF); run(100, 0, 0, 0, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule